// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic datapath of a small 8-bit processor core. Each cycle it takes two operands and an operation code, forms the result combinationally, and works out the next value of an 8-bit status register. The status register is held inside the block and is loaded from that next value on a rising clock edge when the write-back enable is high. Carry and zero inputs to the chained operations are taken from the held status register.

Every operation has its own set of flags that it may change. Flags outside that set pass through unchanged, so code can chain multi-byte arithmetic and keep the carry across logical operations. Subtract-with-carry and compare-with-carry keep a sticky zero, so a multi-byte compare ends with Z set only when all bytes matched. Rotates pass the carry flag through the byte, and the shift operations put the bit that falls out of the byte into the carry.

Top module: `alu8_core`

## Requirements
- R1: After reset the status register reads 0x00. Its bits, from bit 7 down to bit 0, are I, T, H, S, V, N, Z, C. No operation changes I or T.
- R2: ADD (code 0) returns a+b and ADC (code 1) returns a+b+C. Both set C to the carry out of bit 7, H to the carry out of bit 3, V to signed overflow, N to bit 7 of the result and Z to the result being zero.
- R3: SUB (code 2) returns a-b and SBC (code 3) returns a-b-C. C is the borrow out of bit 7, H is the borrow from bit 4 into bit 3, V is signed overflow and N is bit 7. Z follows the result for SUB. For SBC, Z is set only when the result is zero and Z was already set.
- R4: CMP (code 4) and CPC (code 5) set flags exactly as SUB and SBC do, including the sticky zero of CPC, and never assert result_wr.
- R5: AND (6), OR (7), XOR (8), TST (13, result a) and CLR (14, result 0) update only Z, N, S and V, with V cleared. C and H are kept.
- R6: INC (11) and DEC (12) return a+1 and a-1 and update only Z, N, S and V. V is set for INC of 0x7F and for DEC of 0x80. C and H are kept.
- R7: COM (9) returns 0xFF-a with C set and V cleared, and keeps H. NEG (10) returns 0x00-a. C is set when the result is not zero, V is set when the result is 0x80, and H is the borrow into bit 3.
- R8: LSL (15) shifts left with a zero into bit 0 and old bit 7 into C. LSR (16) shifts right with a zero into bit 7 and old bit 0 into C. Both set V to N XOR C after the shift and keep H.
- R9: ROL (17) moves C into bit 0 and old bit 7 into C. ROR (18) moves C into bit 7 and old bit 0 into C. ASR (19) keeps bit 7 and moves old bit 0 into C. All three set V to N XOR C after the shift and keep H.
- R10: SWAP (20) exchanges the upper and lower nibbles and leaves every flag unchanged.
- R11: Whenever an operation updates N or V, S equals N XOR V in the next status value.
- R12: The status register loads sreg_next at a rising edge only when sreg_wr_en is high, and holds otherwise. result_wr equals sreg_wr_en for result-writing operations. Codes 21 to 31 write no result and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 8 | First operand (destination register value) |
| op_b | input | 8 | Second operand or immediate |
| op_sel | input | 5 | Operation code |
| sreg_wr_en | input | 1 | Write-back enable for result and status |
| result | output | 8 | Combinational result |
| result_wr | output | 1 | Result is to be written back this cycle |
| sreg_next | output | 8 | Status value the operation produces |
| sreg_q | output | 8 | Held status register |

## Verification
result, result_wr and sreg_next are combinational, so they are due in the same cycle as the operand and code that produce them. sreg_q is due one rising edge later, and only when the enable was high. The bench drives each operation on a falling edge and compares the combinational outputs a few nanoseconds later, before the next rising edge. Each scoreboard item also carries the status value the model expects to be held by then, which covers the previous operation's write-back or hold. A final operation with the enable low brings the last loaded status out for checking.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_CMP  = 5'd4,
      OP_CPC  = 5'd5,
      OP_AND  = 5'd6,
      OP_OR   = 5'd7,
      OP_XOR  = 5'd8,
      OP_COM  = 5'd9,
      OP_NEG  = 5'd10,
      OP_INC  = 5'd11,
      OP_DEC  = 5'd12,
      OP_TST  = 5'd13,
      OP_CLR  = 5'd14,
      OP_LSL  = 5'd15,
      OP_LSR  = 5'd16,
      OP_ROL  = 5'd17,
      OP_ROR  = 5'd18,
      OP_ASR  = 5'd19,
      OP_SWAP = 5'd20
   } alu_op_e;

   localparam int SR_W = 8;
   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_N = 2;
   localparam int FL_V = 3;
   localparam int FL_S = 4;
   localparam int FL_H = 5;
   localparam int FL_T = 6;
   localparam int FL_I = 7;

   // masks of flags each operation class may change
   localparam logic [SR_W-1:0] MSK_ARITH = 8'h3F; // H S V N Z C
   localparam logic [SR_W-1:0] MSK_ZCNV  = 8'h1F; // S V N Z C
   localparam logic [SR_W-1:0] MSK_ZNV   = 8'h1E; // S V N Z
   localparam logic [SR_W-1:0] MSK_NONE  = 8'h00;

   typedef struct packed {
      logic            use_adder;
      logic            sub;
      logic            use_cin;
      logic            negate;
      logic            one_b;
      logic            sticky_z;
      logic            wr_res;
      logic [SR_W-1:0] mask;
   } alu_ctrl_t;

   function automatic alu_ctrl_t decode_op(input logic [4:0] code);
      alu_ctrl_t c;
      c        = '0;
      c.wr_res = 1'b1;
      case (code)
         OP_ADD:  begin c.use_adder = 1'b1; c.mask = MSK_ARITH; end
         OP_ADC:  begin c.use_adder = 1'b1; c.use_cin = 1'b1; c.mask = MSK_ARITH; end
         OP_SUB:  begin c.use_adder = 1'b1; c.sub = 1'b1; c.mask = MSK_ARITH; end
         OP_SBC:  begin c.use_adder = 1'b1; c.sub = 1'b1; c.use_cin = 1'b1;
                        c.sticky_z = 1'b1; c.mask = MSK_ARITH; end
         OP_CMP:  begin c.use_adder = 1'b1; c.sub = 1'b1; c.wr_res = 1'b0;
                        c.mask = MSK_ARITH; end
         OP_CPC:  begin c.use_adder = 1'b1; c.sub = 1'b1; c.use_cin = 1'b1;
                        c.sticky_z = 1'b1; c.wr_res = 1'b0; c.mask = MSK_ARITH; end
         OP_NEG:  begin c.use_adder = 1'b1; c.sub = 1'b1; c.negate = 1'b1;
                        c.mask = MSK_ARITH; end
         OP_INC:  begin c.use_adder = 1'b1; c.one_b = 1'b1; c.mask = MSK_ZNV; end
         OP_DEC:  begin c.use_adder = 1'b1; c.sub = 1'b1; c.one_b = 1'b1;
                        c.mask = MSK_ZNV; end
         OP_AND, OP_OR, OP_XOR, OP_TST, OP_CLR: c.mask = MSK_ZNV;
         OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: c.mask = MSK_ZCNV;
         OP_SWAP: c.mask = MSK_NONE;
         default: begin c.wr_res = 1'b0; c.mask = MSK_NONE; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
   parameter int W         = 8,
   parameter bit FAST_SUM  = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         c_flag,
   output logic         h_flag,
   output logic         v_flag
);
   localparam int HW = W / 2;

   logic [W-1:0] b_eff;
   logic         ci;
   logic         c_half;
   logic         c_top;

   // subtraction as a + ~b + ~borrow; carry out then means "no borrow"
   assign b_eff = sub ? ~b : b;
   assign ci    = sub ? ~cin : cin;

   if (FAST_SUM) begin : g_fast
      logic [W:0]  full;
      logic [HW:0] low;
      assign full   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci};
      assign low    = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, ci};
      assign sum    = full[W-1:0];
      assign c_top  = full[W];
      assign c_half = low[HW];
   end else begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = ci;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
         assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
      end
      assign c_top  = cy[W];
      assign c_half = cy[HW];
   end

   assign c_flag = sub ? ~c_top  : c_top;
   assign h_flag = sub ? ~c_half : c_half;
   assign v_flag = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [4:0]   op,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         c_flag,
   output logic         v_flag
);
   localparam int HW = W / 2;

   logic shift_op;

   always_comb begin
      res      = a;
      c_flag   = cin;
      shift_op = 1'b0;
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_TST:  res = a;
         OP_CLR:  res = '0;
         OP_COM:  begin res = ~a; c_flag = 1'b1; end
         OP_LSL:  begin res = {a[W-2:0], 1'b0};    c_flag = a[W-1]; shift_op = 1'b1; end
         OP_LSR:  begin res = {1'b0, a[W-1:1]};    c_flag = a[0];   shift_op = 1'b1; end
         OP_ROL:  begin res = {a[W-2:0], cin};     c_flag = a[W-1]; shift_op = 1'b1; end
         OP_ROR:  begin res = {cin, a[W-1:1]};     c_flag = a[0];   shift_op = 1'b1; end
         OP_ASR:  begin res = {a[W-1], a[W-1:1]};  c_flag = a[0];   shift_op = 1'b1; end
         OP_SWAP: res = {a[HW-1:0], a[W-1:HW]};
         default: res = a;
      endcase
      // logical ops and complement clear V; shifts use N xor C after the move
      v_flag = shift_op & (res[W-1] ^ c_flag);
   end

endmodule

// File: rtl/alu8_status.sv
module alu8_status
   import alu8_pkg::*;
#(
   parameter int              W       = 8,
   parameter logic [SR_W-1:0] RST_VAL = 8'h00
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [W-1:0]    res,
   input  logic            c_new,
   input  logic            h_new,
   input  logic            v_new,
   input  logic            sticky_z,
   input  logic [SR_W-1:0] mask,
   output logic [SR_W-1:0] nxt,
   output logic [SR_W-1:0] q
);
   logic [SR_W-1:0] calc;
   logic            n_new;
   logic            z_new;

   assign n_new = res[W-1];
   assign z_new = (res == '0) && (!sticky_z || q[FL_Z]);

   always_comb begin
      calc       = q;
      calc[FL_C] = c_new;
      calc[FL_Z] = z_new;
      calc[FL_N] = n_new;
      calc[FL_V] = v_new;
      calc[FL_S] = n_new ^ v_new;
      calc[FL_H] = h_new;
   end

   assign nxt = (calc & mask) | (q & ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL;
      else if (wr_en) q <= nxt;
   end

   AST_SREG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> q == $past(nxt)) else $error("status not loaded"); // R12
   AST_SREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q)) else $error("status changed without enable"); // R12
   AST_IT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      nxt[FL_I:FL_T] == q[FL_I:FL_T]) else $error("I or T altered"); // R1

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int              W        = 8,
   parameter bit              FAST_SUM = 1'b0,
   parameter logic [SR_W-1:0] RST_VAL  = 8'h00
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W-1:0]    op_a,
   input  logic [W-1:0]    op_b,
   input  logic [4:0]      op_sel,
   input  logic            sreg_wr_en,
   output logic [W-1:0]    result,
   output logic            result_wr,
   output logic [SR_W-1:0] sreg_next,
   output logic [SR_W-1:0] sreg_q
);
   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("alu8_core: W must be even and at least 4");
   end

   alu_ctrl_t    ctl;
   logic [W-1:0] add_a, add_b, add_sum, bit_res;
   logic         add_cin, add_c, add_h, add_v;
   logic         bit_c, bit_v;
   logic         c_new, h_new, v_new;

   assign ctl     = decode_op(op_sel);
   assign add_a   = ctl.negate ? '0 : op_a;
   assign add_b   = ctl.negate ? op_a : (ctl.one_b ? W'(1) : op_b);
   assign add_cin = ctl.use_cin & sreg_q[FL_C];

   alu8_adder #(.W(W), .FAST_SUM(FAST_SUM)) u_adder (
      .a(add_a), .b(add_b), .cin(add_cin), .sub(ctl.sub),
      .sum(add_sum), .c_flag(add_c), .h_flag(add_h), .v_flag(add_v)
   );

   alu8_bitops #(.W(W)) u_bitops (
      .a(op_a), .b(op_b), .op(op_sel), .cin(sreg_q[FL_C]),
      .res(bit_res), .c_flag(bit_c), .v_flag(bit_v)
   );

   assign result = ctl.use_adder ? add_sum : bit_res;
   assign c_new  = ctl.use_adder ? add_c   : bit_c;
   assign h_new  = ctl.use_adder & add_h;
   assign v_new  = ctl.use_adder ? add_v   : bit_v;

   assign result_wr = sreg_wr_en & ctl.wr_res;

   alu8_status #(.W(W), .RST_VAL(RST_VAL)) u_status (
      .clk(clk), .rst_n(rst_n), .wr_en(sreg_wr_en), .res(result),
      .c_new(c_new), .h_new(h_new), .v_new(v_new), .sticky_z(ctl.sticky_z),
      .mask(ctl.mask), .nxt(sreg_next), .q(sreg_q)
   );

   AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_CMP || op_sel == OP_CPC) |-> !result_wr) else $error("compare wrote"); // R4
   AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_SWAP) |-> sreg_next == sreg_q) else $error("swap moved flags"); // R10
   AST_LOGIC_KEEP_CH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel inside {OP_AND, OP_OR, OP_XOR, OP_TST, OP_CLR}) |->
      (sreg_next[FL_C] == sreg_q[FL_C] && sreg_next[FL_H] == sreg_q[FL_H]))
      else $error("logic op altered C or H"); // R5
   AST_COM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == OP_COM) |-> (sreg_next[FL_C] && !sreg_next[FL_V])) else $error("COM flags"); // R7
   AST_S_IS_NV: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel <= 5'(OP_ASR)) |-> sreg_next[FL_S] == (sreg_next[FL_N] ^ sreg_next[FL_V]))
      else $error("S not N xor V"); // R11
   AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > 5'(OP_SWAP)) |-> (!result_wr && sreg_next == sreg_q))
      else $error("undefined op had effect"); // R12

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

   typedef struct packed {
      logic [7:0] r;
      logic       wr;
      logic [7:0] s;
   } exp_t;

   typedef struct {
      exp_t       e;
      logic       we;
      logic       chk_res;
      logic [7:0] sq;
      string      tag;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] op_a = '0, op_b = '0;
   logic [4:0] op_sel = 5'd20;
   logic       sreg_wr_en = 1'b0;
   logic [7:0] result, sreg_next, sreg_q;
   logic       result_wr;

   int    nchk = 0;
   int    nerr = 0;
   bit    done = 0;
   item_t sb[$];
   logic [7:0] mdl_sreg = 8'h00;

   always #5 clk = ~clk;

   alu8_core dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .sreg_wr_en(sreg_wr_en), .result(result), .result_wr(result_wr),
      .sreg_next(sreg_next), .sreg_q(sreg_q)
   );

   function automatic int sgn(input logic [7:0] x);
      return (x >= 8'd128) ? int'(x) - 256 : int'(x);
   endfunction

   // reference model written from the requirements
   function automatic exp_t model(input logic [4:0] op, input logic [7:0] a, b, s);
      exp_t e;
      int ua = int'(a), ub = int'(b), ci, t, st;
      logic [7:0] r = a;
      bit c = s[0], z = s[1], n = s[2], v = s[3], h = s[5], sf = s[4];
      bit upd = 1, sticky = 0, shift = 0, wr = 1;
      ci = 0;
      case (op)
         5'd0, 5'd1: begin
            ci = (op == 5'd1) ? int'(s[0]) : 0;
            t = ua + ub + ci; r = t[7:0]; c = (t > 255);
            h = ((ua % 16) + (ub % 16) + ci) > 15;
            st = sgn(a) + sgn(b) + ci; v = (st > 127 || st < -128);
         end
         5'd2, 5'd3, 5'd4, 5'd5: begin
            ci = (op == 5'd3 || op == 5'd5) ? int'(s[0]) : 0;
            sticky = (op == 5'd3 || op == 5'd5);
            wr = (op < 5'd4);
            t = ua - ub - ci; r = t[7:0]; c = (t < 0);
            h = ((ua % 16) - (ub % 16) - ci) < 0;
            st = sgn(a) - sgn(b) - ci; v = (st > 127 || st < -128);
         end
         5'd6:  begin r = a & b; v = 0; end
         5'd7:  begin r = a | b; v = 0; end
         5'd8:  begin r = a ^ b; v = 0; end
         5'd13: begin r = a;     v = 0; end
         5'd14: begin r = 8'h00; v = 0; end
         5'd9:  begin r = 8'hFF - a; c = 1; v = 0; end
         5'd10: begin
            t = 0 - ua; r = t[7:0]; c = (r != 8'h00); v = (r == 8'h80);
            h = (ua % 16) != 0;
         end
         5'd11: begin r = a + 8'd1; v = (a == 8'h7F); end
         5'd12: begin r = a - 8'd1; v = (a == 8'h80); end
         5'd15: begin r = {a[6:0], 1'b0}; c = a[7]; shift = 1; end
         5'd16: begin r = {1'b0, a[7:1]}; c = a[0]; shift = 1; end
         5'd17: begin r = {a[6:0], s[0]}; c = a[7]; shift = 1; end
         5'd18: begin r = {s[0], a[7:1]}; c = a[0]; shift = 1; end
         5'd19: begin r = {a[7], a[7:1]}; c = a[0]; shift = 1; end
         5'd20: begin r = {a[3:0], a[7:4]}; upd = 0; end
         default: begin upd = 0; wr = 0; end
      endcase
      if (upd) begin
         n = r[7];
         z = sticky ? ((r == 8'h00) && s[1]) : (r == 8'h00);
         if (shift) v = n ^ c;
         sf = n ^ v;
      end
      e.r = r;
      e.wr = wr;
      e.s = {s[7:6], h, sf, v, n, z, c};
      return e;
   endfunction

   task automatic chk(input string tag, input string what, input logic [7:0] act, exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: applies one operation on a falling edge, pushes the expectation
   task automatic run(input logic [4:0] op, input logic [7:0] a, b,
                      input logic we, input string tag);
      item_t it;
      @(negedge clk);
      op_sel = op; op_a = a; op_b = b; sreg_wr_en = we;
      it.e       = model(op, a, b, mdl_sreg);
      it.we      = we;
      it.chk_res = (op != 5'd4 && op != 5'd5 && op <= 5'd20);
      it.sq      = mdl_sreg;
      it.tag     = tag;
      sb.push_back(it);
      if (we) mdl_sreg = it.e.s;
   endtask

   // monitor: compares combinational outputs before the next rising edge
   initial begin
      forever begin
         @(negedge clk);
         #3;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk(it.tag, "sreg_q", sreg_q, it.sq);
            chk(it.tag, "sreg_next", sreg_next, it.e.s);
            chk(it.tag, "result_wr", {7'd0, result_wr}, {7'd0, it.we & it.e.wr});
            if (it.chk_res) chk(it.tag, "result", result, it.e.r);
         end
      end
   end

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset value, SWAP without enable leaves it visible
      run(5'd20, 8'h00, 8'h00, 1'b0, "R1");
      // R2 add family
      run(5'd0, 8'h0F, 8'h01, 1'b1, "R2");
      run(5'd0, 8'h7F, 8'h01, 1'b1, "R2");
      run(5'd0, 8'hFF, 8'h01, 1'b1, "R2");
      run(5'd1, 8'h10, 8'h20, 1'b1, "R2");
      run(5'd1, 8'h80, 8'h80, 1'b1, "R2");
      // R3 subtract family
      run(5'd2, 8'h10, 8'h01, 1'b1, "R3");
      run(5'd2, 8'h00, 8'h01, 1'b1, "R3");
      run(5'd3, 8'h05, 8'h04, 1'b1, "R3");
      run(5'd2, 8'h33, 8'h33, 1'b1, "R3");
      run(5'd3, 8'h07, 8'h07, 1'b1, "R3");
      run(5'd2, 8'h80, 8'h01, 1'b1, "R3");
      // R4 compare, sticky zero in both directions
      run(5'd4, 8'h01, 8'h00, 1'b1, "R4");
      run(5'd5, 8'h00, 8'h00, 1'b1, "R4");
      run(5'd4, 8'h55, 8'h55, 1'b1, "R4");
      run(5'd5, 8'h12, 8'h12, 1'b1, "R4");
      run(5'd4, 8'h10, 8'h20, 1'b1, "R4");
      // set C and H before logic ops: 0x00-0x01 borrows everywhere
      run(5'd2, 8'h00, 8'h01, 1'b1, "R3");
      run(5'd6, 8'hF0, 8'h0F, 1'b1, "R5");
      run(5'd7, 8'h80, 8'h01, 1'b1, "R5");
      run(5'd8, 8'hAA, 8'hAA, 1'b1, "R5");
      run(5'd13, 8'h9C, 8'h00, 1'b1, "R5");
      run(5'd14, 8'h5A, 8'h00, 1'b1, "R5");
      // R6 increment and decrement
      run(5'd11, 8'h7F, 8'h00, 1'b1, "R6");
      run(5'd11, 8'hFF, 8'h00, 1'b1, "R6");
      run(5'd12, 8'h80, 8'h00, 1'b1, "R6");
      run(5'd12, 8'h01, 8'h00, 1'b1, "R6");
      // R7 complements
      run(5'd9, 8'h5A, 8'h00, 1'b1, "R7");
      run(5'd10, 8'h00, 8'h00, 1'b1, "R7");
      run(5'd10, 8'h80, 8'h00, 1'b1, "R7");
      run(5'd10, 8'h01, 8'h00, 1'b1, "R7");
      // R8 logical shifts
      run(5'd15, 8'h81, 8'h00, 1'b1, "R8");
      run(5'd15, 8'h40, 8'h00, 1'b1, "R8");
      run(5'd16, 8'h01, 8'h00, 1'b1, "R8");
      run(5'd16, 8'hFE, 8'h00, 1'b1, "R8");
      // R9 rotates through carry and arithmetic shift
      run(5'd9, 8'h00, 8'h00, 1'b1, "R9");
      run(5'd17, 8'h40, 8'h00, 1'b1, "R9");
      run(5'd18, 8'h01, 8'h00, 1'b1, "R9");
      run(5'd18, 8'h02, 8'h00, 1'b1, "R9");
      run(5'd19, 8'h81, 8'h00, 1'b1, "R9");
      run(5'd19, 8'h42, 8'h00, 1'b1, "R9");
      // R10 swap with flags set
      run(5'd0, 8'hFF, 8'h01, 1'b1, "R10");
      run(5'd20, 8'h3C, 8'h00, 1'b1, "R10");
      run(5'd20, 8'hA5, 8'h00, 1'b1, "R10");
      // R11 S follows N xor V: positive overflow gives N=1 V=1 S=0
      run(5'd0, 8'h40, 8'h40, 1'b1, "R11");
      run(5'd2, 8'h80, 8'h01, 1'b1, "R11");
      // R12 hold without enable, undefined codes
      run(5'd0, 8'hFF, 8'hFF, 1'b0, "R12");
      run(5'd2, 8'h00, 8'h01, 1'b0, "R12");
      run(5'd25, 8'h12, 8'h34, 1'b1, "R12");
      run(5'd31, 8'h00, 8'h00, 1'b1, "R12");
      run(5'd0, 8'h01, 8'h01, 1'b1, "R12");
      run(5'd20, 8'h00, 8'h00, 1'b0, "R12");
      wait (sb.size() == 0);
      repeat (2) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end

endmodule